// File: doc/BRIEF.md
# Shutdown and Wake-up Controller

This block runs on a 32.768 kHz always-on clock and drives the enable line of the main power supply. Software turns main power off by writing a keyed command to the control word. Power then stays off until an enabled wake source asks for it again. The block has sixteen external wake-up pins, an RTC alarm input and an RTT alarm input.

Each pin has its own enable bit and its own active level. All pins share one debounce length, picked from a fixed table of slow-clock counts. A pin only counts as a wake event after it has stayed at its active level for the full length. When power returns, the status word keeps a record of which sources caused the wake-up. Software reads that record once; the read clears it.

All wake inputs pass through a two-flop synchronizer. Each pin then has its own debounce counter. The counter restarts as soon as the pin leaves its active level.

Top module: `pwr_shdn_ctrl`

## Requirements
- R1: After reset, `pwr_en` is 1. The mode, status and wake-configuration words all read zero.
- R2: A write to offset 0x00 starts shutdown when bit 0 is 1 and bits 31:24 equal 0xA5. `pwr_en` is then 0 after the next clock edge.
- R3: A control write does not start shutdown if its key is not 0xA5 or if its bit 0 is 0.
- R4: In the wake-configuration word at offset 0x0C, bit i (0..15) enables pin i. Bit 16+i sets the active level of pin i: 1 means high, 0 means low. A disabled pin never wakes the block.
- R5: The debounce selector S sits in bits 31:24 of the mode word at offset 0x04. S values 0 to 5 give a length N of 0, 3, 32, 512, 4096 or 32768 cycles. Take the pin reaching its active level just before clock edge 1. `pwr_en` then returns to 1 at edge N+3: two synchronizer edges, N counting edges, and one edge to register the wake.
- R6: A selector value of 6 or more behaves like 5.
- R7: Mode bit 17 enables RTC alarm wake-up and mode bit 16 enables RTT alarm wake-up. An enabled alarm wakes the block at the third edge after it rises. A disabled alarm has no effect.
- R8: The status word at offset 0x08 is latched on the edge where `pwr_en` returns to 1. Bit 16+i is set for each pin that qualified in that cycle. Bit 5 flags an RTC wake and bit 4 flags an RTT wake.
- R9: A read of the status word returns its value and clears it, so the next read returns zero.
- R10: If an active pin goes back to its inactive level before N cycles have passed, its count restarts. A later wake then takes the full N+3 edges again.
- R11: If the mode and wake-configuration words are both zero, no pin level and no alarm brings power back.
- R12: The mode word reads back as the selector in bits 31:24, the RTC enable in bit 17 and the RTT enable in bit 16, with all other bits zero. The wake-configuration word reads back in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz slow clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a status read clears the status) |
| bus_addr | input | 4 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high, zero otherwise |
| wake_pin | input | 16 | External wake-up pins |
| rtc_alarm | input | 1 | RTC alarm request |
| rtt_alarm | input | 1 | RTT alarm request |
| pwr_en | output | 1 | Main power enable, 1 = powered |

## Verification
The bench walks a table of vectors. Each vector pairs a debounce selector with a different pin and an active level. Every selector from 0 to 5 is covered, and one vector uses an out-of-range selector. The bench measures the exact number of edges between the pin change and the return of power. This tells apart an off-by-one in the synchronizer or counter, a wrong table entry, a broken clamp for large selectors, and an inverted polarity.

Directed tests cover these cases:
- a bad key and a missing command bit,
- a pulse cut short before the count completes,
- a disabled pin,
- an alarm that is disabled while its partner is enabled,
- an all-zero configuration.

Each directed test separates "no wake" from "wrong source recorded" by reading the status word.

// File: rtl/shdn_pkg.sv
package shdn_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int PIN_N   = 16;
    localparam int CNT_W   = 16;
    localparam int SEL_W   = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_MODE = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_WCFG = 4'hC;

    localparam logic [7:0] SHDN_KEY = 8'hA5;

    typedef struct packed {
        logic [SEL_W-1:0] dbc_sel;
        logic             rtc_en;
        logic             rtt_en;
    } mode_t;

    typedef struct packed {
        logic [PIN_N-1:0] pol;
        logic [PIN_N-1:0] en;
    } wcfg_t;

    typedef enum logic {
        PWR_OFF = 1'b0,
        PWR_ON  = 1'b1
    } pwr_state_t;

    // Selector to required active-cycle count; values past the table saturate.
    function automatic logic [CNT_W-1:0] dbc_limit(input logic [SEL_W-1:0] sel);
        case (sel)
            8'd0:    dbc_limit = 16'd0;
            8'd1:    dbc_limit = 16'd3;
            8'd2:    dbc_limit = 16'd32;
            8'd3:    dbc_limit = 16'd512;
            8'd4:    dbc_limit = 16'd4096;
            default: dbc_limit = 16'd32768;
        endcase
    endfunction

endpackage

// File: rtl/shdn_sync.sv
module shdn_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/shdn_debounce.sv
module shdn_debounce
    import shdn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl,
    input  logic             pol,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic             active;
    logic [CNT_W-1:0] cnt_q;

    assign active = pol ? lvl : ~lvl;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (!active)      cnt_q <= '0;
        else if (cnt_q < limit) cnt_q <= cnt_q + 1'b1;
    end

    assign hit = active && (cnt_q >= limit);

    // R10
    dbc_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt_q == '0))
        else $error("debounce count not restarted");

    // R5
    dbc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && limit != '0) |-> $past(active))
        else $error("debounce qualified without prior active cycle");
endmodule

// File: rtl/shdn_regs.sv
module shdn_regs
    import shdn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] stat_in,
    output mode_t             mode_o,
    output wcfg_t             wcfg_o,
    output logic              shdn_req,
    output logic              stat_clr
);
    mode_t mode_q;
    wcfg_t wcfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            wcfg_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_MODE) begin
                mode_q.dbc_sel <= bus_wdata[31:24];
                mode_q.rtc_en  <= bus_wdata[17];
                mode_q.rtt_en  <= bus_wdata[16];
            end
            if (bus_addr == OFS_WCFG) begin
                wcfg_q.pol <= bus_wdata[31:16];
                wcfg_q.en  <= bus_wdata[15:0];
            end
        end
    end

    assign shdn_req = bus_wr && (bus_addr == OFS_CTRL) &&
                      (bus_wdata[31:24] == SHDN_KEY) && bus_wdata[0];
    assign stat_clr = bus_rd && (bus_addr == OFS_STAT);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_MODE: bus_rdata = {mode_q.dbc_sel, 6'b0, mode_q.rtc_en, mode_q.rtt_en, 16'b0};
                OFS_STAT: bus_rdata = stat_in;
                OFS_WCFG: bus_rdata = wcfg_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign mode_o = mode_q;
    assign wcfg_o = wcfg_q;
endmodule

// File: rtl/shdn_pwr.sv
module shdn_pwr
    import shdn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shdn_req,
    input  logic              stat_clr,
    input  logic [PIN_N-1:0]  pin_hit,
    input  logic              rtc_hit,
    input  logic              rtt_hit,
    output logic              pwr_en,
    output logic [DATA_W-1:0] status
);
    pwr_state_t        state_q;
    logic [DATA_W-1:0] stat_q;
    logic              wake_any;
    logic [DATA_W-1:0] wake_word;

    assign wake_any  = (|pin_hit) || rtc_hit || rtt_hit;
    assign wake_word = {pin_hit, 10'b0, rtc_hit, rtt_hit, 4'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PWR_ON;
            stat_q  <= '0;
        end else begin
            if (stat_clr) stat_q <= '0;
            case (state_q)
                PWR_ON:  if (shdn_req) state_q <= PWR_OFF;
                PWR_OFF: if (wake_any) begin
                    state_q <= PWR_ON;
                    stat_q  <= wake_word;
                end
                default: state_q <= PWR_ON;
            endcase
        end
    end

    assign pwr_en = (state_q == PWR_ON);
    assign status = stat_q;

    // R2
    shdn_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_en && shdn_req) |=> !pwr_en)
        else $error("accepted shutdown did not drop power");

    // R11
    stay_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwr_en && !wake_any) |=> !pwr_en)
        else $error("power returned without wake source");

    // R8
    wake_latch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_en) |-> (stat_q != '0))
        else $error("wake without latched source");

    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && pwr_en) |=> (stat_q == '0))
        else $error("status not cleared by read");
endmodule

// File: rtl/pwr_shdn_ctrl.sv
module pwr_shdn_ctrl
    import shdn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_N-1:0]  wake_pin,
    input  logic              rtc_alarm,
    input  logic              rtt_alarm,
    output logic              pwr_en
);
    localparam int SYNC_W = PIN_N + 2;

    mode_t             mode;
    wcfg_t             wcfg;
    logic              shdn_req;
    logic              stat_clr;
    logic [DATA_W-1:0] status;
    logic [SYNC_W-1:0] in_s;
    logic [PIN_N-1:0]  raw_hit;
    logic [PIN_N-1:0]  pin_hit;
    logic [CNT_W-1:0]  limit;
    logic              rtc_hit;
    logic              rtt_hit;

    shdn_regs u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stat_in(status), .mode_o(mode), .wcfg_o(wcfg),
        .shdn_req(shdn_req), .stat_clr(stat_clr)
    );

    shdn_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({rtc_alarm, rtt_alarm, wake_pin}), .q(in_s)
    );

    assign limit = dbc_limit(mode.dbc_sel);

    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        shdn_debounce u_dbc (
            .clk(clk), .rst(rst), .lvl(in_s[i]), .pol(wcfg.pol[i]),
            .limit(limit), .hit(raw_hit[i])
        );
    end

    assign pin_hit = raw_hit & wcfg.en;
    assign rtc_hit = mode.rtc_en && in_s[PIN_N+1];
    assign rtt_hit = mode.rtt_en && in_s[PIN_N];

    shdn_pwr u_pwr (
        .clk(clk), .rst(rst), .shdn_req(shdn_req), .stat_clr(stat_clr),
        .pin_hit(pin_hit), .rtc_hit(rtc_hit), .rtt_hit(rtt_hit),
        .pwr_en(pwr_en), .status(status)
    );

    // R3
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_en && bus_wr && bus_addr == OFS_CTRL &&
         (bus_wdata[31:24] != SHDN_KEY || !bus_wdata[0])) |=> pwr_en)
        else $error("unkeyed control write dropped power");
endmodule

// File: tb/pwr_shdn_ctrl_tb.sv
module pwr_shdn_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    localparam int V_SEL [NV] = '{0, 1, 2, 3, 4, 7, 5};
    localparam int V_PIN [NV] = '{0, 3, 7, 15, 9, 2, 1};
    localparam int V_POL [NV] = '{1, 0, 1, 0, 1, 1, 0};
    localparam int V_EXP [NV] = '{3, 6, 35, 515, 4099, 32771, 32771};

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [15:0] wake_pin = 0;
    logic        rtc_alarm = 0, rtt_alarm = 0;
    logic        pwr_en;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_shdn_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wake_pin(wake_pin), .rtc_alarm(rtc_alarm), .rtt_alarm(rtt_alarm),
        .pwr_en(pwr_en)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic wait_wake(input int lim, output int cyc);
        cyc = 0;
        while (cyc < lim && !pwr_en) begin
            @(posedge clk); @(negedge clk);
            cyc++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        idle(3);
        rst = 0;
        idle(1);

        // R1 reset state
        check(pwr_en == 1'b1, "R1 pwr_en after reset", {31'b0, pwr_en}, 1);
        bus_read(4'h4, rd); check(rd == 0, "R1 mode reset", rd, 0);
        bus_read(4'h8, rd); check(rd == 0, "R1 status reset", rd, 0);
        bus_read(4'hC, rd); check(rd == 0, "R1 wcfg reset", rd, 0);

        // R12 readback
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_read(4'h4, rd); check(rd == 32'hFF03_0000, "R12 mode readback", rd, 32'hFF03_0000);
        bus_write(4'hC, 32'hA5A5_1234);
        bus_read(4'hC, rd); check(rd == 32'hA5A5_1234, "R12 wcfg readback", rd, 32'hA5A5_1234);
        bus_write(4'h4, 0); bus_write(4'hC, 0);

        // R3 bad key, missing command bit
        bus_write(4'h0, 32'h5A00_0001);
        check(pwr_en == 1'b1, "R3 wrong key", {31'b0, pwr_en}, 1);
        bus_write(4'h0, 32'hA500_0000);
        check(pwr_en == 1'b1, "R3 bit0 clear", {31'b0, pwr_en}, 1);

        // Table: R5 / R6 timing, R4 polarity, R8 status, R9 clear-on-read, R2 accept
        for (int v = 0; v < NV; v++) begin
            wake_pin = (V_POL[v] != 0) ? 16'h0000 : 16'hFFFF;
            bus_write(4'h4, V_SEL[v] << 24);
            bus_write(4'hC, (32'(V_POL[v]) << (16 + V_PIN[v])) | (32'd1 << V_PIN[v]));
            idle(4);
            bus_write(4'h0, 32'hA500_0001);
            check(pwr_en == 1'b0, "R2 keyed shutdown", {31'b0, pwr_en}, 0);
            wake_pin[V_PIN[v]] = (V_POL[v] != 0);
            wait_wake(40000, cyc);
            check(cyc == V_EXP[v], (V_SEL[v] > 5) ? "R6 clamped selector wake edges" : "R5 debounce wake edges",
                  cyc, V_EXP[v]);
            bus_read(4'h8, rd);
            check(rd == (32'd1 << (16 + V_PIN[v])), "R8 R4 pin status", rd, 32'd1 << (16 + V_PIN[v]));
            bus_read(4'h8, rd);
            check(rd == 0, "R9 status cleared", rd, 0);
        end

        // R10 short pulse restarts count
        wake_pin = 0;
        bus_write(4'h4, 32'h0200_0000);
        bus_write(4'hC, 32'h0040_0040);
        idle(4);
        bus_write(4'h0, 32'hA500_0001);
        wake_pin[6] = 1; idle(20);
        wake_pin[6] = 0; idle(5);
        check(pwr_en == 1'b0, "R10 short pulse no wake", {31'b0, pwr_en}, 0);
        wake_pin[6] = 1;
        wait_wake(100, cyc);
        check(cyc == 35, "R10 full count after restart", cyc, 35);
        bus_read(4'h8, rd);

        // R4 disabled pin ignored
        wake_pin = 0;
        bus_write(4'h4, 0);
        bus_write(4'hC, 32'h0010_0010);
        idle(4);
        bus_write(4'h0, 32'hA500_0001);
        wake_pin[5] = 1; idle(20);
        check(pwr_en == 1'b0, "R4 disabled pin", {31'b0, pwr_en}, 0);
        wake_pin[4] = 1;
        wait_wake(20, cyc);
        check(cyc == 3, "R4 enabled pin wake", cyc, 3);
        bus_read(4'h8, rd);
        check(rd == 32'h0010_0000, "R4 R8 only enabled pin latched", rd, 32'h0010_0000);
        wake_pin = 0;

        // R7 RTC wake
        bus_write(4'hC, 0);
        bus_write(4'h4, 32'h0002_0000);
        idle(4);
        bus_write(4'h0, 32'hA500_0001);
        rtc_alarm = 1;
        wait_wake(20, cyc);
        check(cyc == 3, "R7 RTC wake edges", cyc, 3);
        bus_read(4'h8, rd);
        check(rd == 32'h20, "R7 R8 RTC status bit5", rd, 32'h20);
        rtc_alarm = 0;

        // R7 RTC disabled, RTT enabled
        bus_write(4'h4, 32'h0001_0000);
        idle(4);
        bus_write(4'h0, 32'hA500_0001);
        rtc_alarm = 1; idle(20);
        check(pwr_en == 1'b0, "R7 disabled RTC ignored", {31'b0, pwr_en}, 0);
        rtt_alarm = 1;
        wait_wake(20, cyc);
        check(cyc == 3, "R7 RTT wake edges", cyc, 3);
        bus_read(4'h8, rd);
        check(rd == 32'h10, "R7 R8 RTT status bit4", rd, 32'h10);

        // R11 all-zero configuration
        bus_write(4'h4, 0); bus_write(4'hC, 0);
        bus_write(4'h0, 32'hA500_0001);
        wake_pin = 16'hFFFF; rtc_alarm = 1; rtt_alarm = 1; idle(50);
        check(pwr_en == 1'b0, "R11 no wake source", {31'b0, pwr_en}, 0);
        wake_pin = 16'h0000; idle(50);
        check(pwr_en == 1'b0, "R11 no wake low levels", {31'b0, pwr_en}, 0);

        // R1 reset again
        rst = 1; idle(2); rst = 0; idle(1);
        check(pwr_en == 1'b1, "R1 pwr_en after second reset", {31'b0, pwr_en}, 1);
        bus_read(4'h8, rd); check(rd == 0, "R1 status after second reset", rd, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule